// File: doc/BRIEF.md
# Card Command Issue and Response Capture Engine

This block takes a command word and a 32-bit argument from a register-style write interface and sends the command to a card port. The command goes out as a 6-bit index plus the argument. The card answers over a request/acknowledge handshake. It returns an error flag, a response length in bytes and up to sixteen response bytes. The engine checks that length against the response type the command asked for. It packs valid response bytes big-endian into four 32-bit response words and records the outcome in sticky status flags.

A small state machine sequences the work:

- **IDLE** waits for a command write.
- **WAIT** holds the card request high until the acknowledge arrives.
- **CHECK** judges the captured answer, loads the response words, sets one status flag and pulses the data-path start.
- **DROP** lets a command marked pending finish without contacting the card.

The transitions are:

- IDLE→WAIT: a command write with enable set and pending clear.
- IDLE→DROP: a command write with both enable and pending set.
- WAIT→CHECK: the card acknowledges.
- CHECK→IDLE and DROP→IDLE: unconditional.

In both CHECK and DROP the enable bit of the stored command word clears itself. The interrupt-mode bit is stored but has no effect.

Top module: `card_cmd_engine`

## Requirements
- R1: A write on `cmd_wr` while idle stores `cmd_wdata[10:0]`. The fields are: index in bits 5:0, expect-response in bit 6, long-response in bit 7, interrupt mode in bit 8, pending in bit 9 and enable in bit 10. If enable is 1 and pending is 0, `card_req` rises the next cycle with `card_index` equal to bits 5:0. Bit 8 does not change this behaviour.
- R2: A write on `arg_wr` while idle stores all 32 bits. `card_arg` presents them unchanged and holds steady while `card_req` waits for `card_ack`.
- R3: A command write with both enable and pending set raises no `card_req`, leaves `status` unchanged and gives no `data_start`. Its stored enable bit reads 0 two cycles after the write.
- R4: A command write with enable 0 only stores the word: `busy` and `card_req` stay low. After an issued command finishes, whatever its outcome, `cmd_reg[10]` reads 0.
- R5: The timeout flag, `status[2]`, is set in any of these cases:
  - the card reports `card_err`;
  - a response is expected and the length is 0;
  - a response is expected and the length is 4 while long was requested;
  - a response is expected and the length is anything other than 4 or 16.

  On a timeout the response words keep their earlier values.
- R6: An expected response that passes the length check sets `status[6]`. A command expecting no response, without card error, sets `status[7]` whatever the returned length.
- R7: Card byte k arrives on `card_resp[8k+7:8k]`. For a valid 4-byte response, word 0 (`rsp_words[31:0]`) becomes {byte0,byte1,byte2,byte3}, and words 1 to 3 become 0.
- R8: For a valid 16-byte response, word w (`rsp_words[32w+31:32w]`) becomes {byte4w,…,byte4w+3}, except that bit 0 of word 3 is forced to 0.
- R9: `data_start` is high for exactly one cycle. That cycle is the one in which an issued command completes, and in the next cycle `busy` and `cmd_reg[10]` are low.
- R10: Command and argument writes made while `busy` is high are ignored.
- R11: Status flags are sticky. Writing 1 to a bit of `status_clr` clears that flag. A flag being set in the same cycle as its clear ends up set.
- R12: After reset, `status`, `rsp_words` and `cmd_reg` read 0, and `busy`, `card_req` and `data_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write data |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument write data |
| status_clr | input | 8 | Write-one-to-clear mask for status flags |
| card_ack | input | 1 | Card answer valid, completes the request |
| card_err | input | 1 | Card reports failure |
| card_len | input | 5 | Response length in bytes |
| card_resp | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| card_req | output | 1 | Request to the card, held until acknowledged |
| card_index | output | 6 | Command index sent to the card |
| card_arg | output | 32 | Argument sent to the card |
| cmd_reg | output | 11 | Stored command word |
| rsp_words | output | 128 | Response words, word w at bits 32w+31:32w |
| status | output | 8 | Flags: bit 2 timeout, bit 6 response, bit 7 sent |
| busy | output | 1 | Engine not idle |
| data_start | output | 1 | One-cycle start pulse to the data path |

## Verification
Two functions can act in the same cycle. The first is the completion of a command, which sets a status flag. The second is a software clear of that same flag. The bench drives `status_clr` with all ones in the CHECK cycle, which it finds by seeing `data_start` high. It also has a timeout flag left standing from an earlier command. The bench then expects only the new outcome flag to remain, so the old flag is shown cleared and the new flag is shown winning. A second overlap is a command write that arrives while a request is outstanding; the bench checks that the stored word and the argument sent to the card stay unchanged.

// File: rtl/ccmd_pkg.sv
package ccmd_pkg;
    localparam int IDX_W      = 6;
    localparam int CMD_W      = 11;
    localparam int BIT_RESP   = 6;
    localparam int BIT_LONG   = 7;
    localparam int BIT_IRQ    = 8;
    localparam int BIT_PEND   = 9;
    localparam int BIT_EN     = 10;
    localparam int STAT_W     = 8;
    localparam int ST_TIMEOUT = 2;
    localparam int ST_RESPOK  = 6;
    localparam int ST_SENT    = 7;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_CHECK = 2'd2,
        S_DROP  = 2'd3
    } ccmd_state_e;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_SENT = 2'd1,
        OUT_RESP = 2'd2,
        OUT_TMO  = 2'd3
    } ccmd_outcome_e;
endpackage

// File: rtl/ccmd_ctrl.sv
module ccmd_ctrl
    import ccmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        wr_en_bit,
    input  logic        wr_pend_bit,
    input  logic        card_ack,
    output ccmd_state_e state,
    output logic        load_cmd,
    output logic        load_arg_ok,
    output logic        capture,
    output logic        finish,
    output logic        drop
);
    ccmd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        load_cmd    = 1'b0;
        load_arg_ok = 1'b0;
        capture     = 1'b0;
        finish      = 1'b0;
        drop        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                load_cmd    = cmd_wr;
                load_arg_ok = 1'b1;
                if (cmd_wr && wr_en_bit)
                    state_d = wr_pend_bit ? S_DROP : S_WAIT;
            end
            S_WAIT: begin
                if (card_ack) begin
                    capture = 1'b1;
                    state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                finish  = 1'b1;
                state_d = S_IDLE;
            end
            S_DROP: begin
                drop    = 1'b1;
                state_d = S_IDLE;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/ccmd_resp_pack.sv
module ccmd_resp_pack
    import ccmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5
) (
    input  logic                       want_resp,
    input  logic                       want_long,
    input  logic                       err,
    input  logic [LEN_W-1:0]           len,
    input  logic [NWORDS*WORD_W-1:0]   bytes_in,
    output ccmd_outcome_e              outcome,
    output logic [NWORDS*WORD_W-1:0]   words_out
);
    localparam int BPW       = WORD_W / 8;
    localparam int SHORT_LEN = BPW;
    localparam int LONG_LEN  = NWORDS * BPW;

    logic short_len, long_len, len_bad;

    assign short_len = (len == LEN_W'(SHORT_LEN));
    assign long_len  = (len == LEN_W'(LONG_LEN));
    assign len_bad   = (len == '0) || (short_len && want_long) || !(short_len || long_len);

    always_comb begin
        if (err)                 outcome = OUT_TMO;
        else if (!want_resp)     outcome = OUT_SENT;
        else if (len_bad)        outcome = OUT_TMO;
        else                     outcome = OUT_RESP;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] full;
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign full[WORD_W-1-8*b -: 8] = bytes_in[8*(w*BPW+b) +: 8];
        end
        if (w == 0) begin : g_first
            assign words_out[w*WORD_W +: WORD_W] = full;
        end else if (w == NWORDS-1) begin : g_last
            assign words_out[w*WORD_W +: WORD_W] = short_len ? '0 : {full[WORD_W-1:1], 1'b0};
        end else begin : g_mid
            assign words_out[w*WORD_W +: WORD_W] = short_len ? '0 : full;
        end
    end
endmodule

// File: rtl/ccmd_flags.sv
module ccmd_flags
    import ccmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  ccmd_outcome_e     outcome,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] flags
);
    logic [STAT_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (finish) begin
            unique case (outcome)
                OUT_SENT: set_vec[ST_SENT]    = 1'b1;
                OUT_RESP: set_vec[ST_RESPOK]  = 1'b1;
                OUT_TMO:  set_vec[ST_TIMEOUT] = 1'b1;
                OUT_NONE: set_vec             = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_vec;
    end
endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
    import ccmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int LEN_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [WORD_W-1:0]         cmd_wdata,
    input  logic                      arg_wr,
    input  logic [WORD_W-1:0]         arg_wdata,
    input  logic [STAT_W-1:0]         status_clr,
    input  logic                      card_ack,
    input  logic                      card_err,
    input  logic [LEN_W-1:0]          card_len,
    input  logic [NWORDS*WORD_W-1:0]  card_resp,
    output logic                      card_req,
    output logic [IDX_W-1:0]          card_index,
    output logic [WORD_W-1:0]         card_arg,
    output logic [CMD_W-1:0]          cmd_reg,
    output logic [NWORDS*WORD_W-1:0]  rsp_words,
    output logic [STAT_W-1:0]         status,
    output logic                      busy,
    output logic                      data_start
);
    localparam int RESP_W = NWORDS * WORD_W;

    ccmd_state_e        state;
    ccmd_outcome_e      outcome;
    logic               load_cmd, load_arg_ok, capture, finish, drop;
    logic [CMD_W-1:0]   cmd_q;
    logic [WORD_W-1:0]  arg_q;
    logic               cap_err;
    logic [LEN_W-1:0]   cap_len;
    logic [RESP_W-1:0]  cap_bytes;
    logic [RESP_W-1:0]  packed_words;
    logic [RESP_W-1:0]  rsp_q;

    ccmd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .wr_en_bit   (cmd_wdata[BIT_EN]),
        .wr_pend_bit (cmd_wdata[BIT_PEND]),
        .card_ack    (card_ack),
        .state       (state),
        .load_cmd    (load_cmd),
        .load_arg_ok (load_arg_ok),
        .capture     (capture),
        .finish      (finish),
        .drop        (drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            arg_q <= '0;
        end else begin
            if (load_cmd)
                cmd_q <= cmd_wdata[CMD_W-1:0];
            else if (finish || drop)
                cmd_q[BIT_EN] <= 1'b0;
            if (arg_wr && load_arg_ok)
                arg_q <= arg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_err   <= 1'b0;
            cap_len   <= '0;
            cap_bytes <= '0;
        end else if (capture) begin
            cap_err   <= card_err;
            cap_len   <= card_len;
            cap_bytes <= card_resp;
        end
    end

    ccmd_resp_pack #(.WORD_W(WORD_W), .NWORDS(NWORDS), .LEN_W(LEN_W)) u_pack (
        .want_resp (cmd_q[BIT_RESP]),
        .want_long (cmd_q[BIT_LONG]),
        .err       (cap_err),
        .len       (cap_len),
        .bytes_in  (cap_bytes),
        .outcome   (outcome),
        .words_out (packed_words)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            rsp_q <= '0;
        else if (finish && outcome == OUT_RESP) rsp_q <= packed_words;
    end

    ccmd_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .finish  (finish),
        .outcome (outcome),
        .clr     (status_clr),
        .flags   (status)
    );

    assign card_req   = (state == S_WAIT);
    assign card_index = cmd_q[IDX_W-1:0];
    assign card_arg   = arg_q;
    assign cmd_reg    = cmd_q;
    assign rsp_words  = rsp_q;
    assign busy       = (state != S_IDLE);
    assign data_start = finish;
endmodule

// File: rtl/ccmd_checker.sv
module ccmd_checker
    import ccmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_wr,
    input logic [WORD_W-1:0]         cmd_wdata,
    input logic                      card_ack,
    input logic                      card_req,
    input logic [IDX_W-1:0]          card_index,
    input logic [WORD_W-1:0]         card_arg,
    input logic [CMD_W-1:0]          cmd_reg,
    input logic [NWORDS*WORD_W-1:0]  rsp_words,
    input logic [STAT_W-1:0]         status,
    input logic                      busy,
    input logic                      data_start
);
    a_r1_issue_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_wdata[BIT_EN] && !cmd_wdata[BIT_PEND])
        |=> (card_req && card_index == $past(cmd_wdata[IDX_W-1:0])));

    a_r2_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && !card_ack) |=> (card_req && $stable(card_arg) && $stable(card_index)));

    a_r3_pending_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_wdata[BIT_EN] && cmd_wdata[BIT_PEND])
        |=> (!card_req && !data_start) ##1 (!cmd_reg[BIT_EN] && !busy));

    a_r9_start_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        data_start |=> (!busy && !cmd_reg[BIT_EN] && !data_start));

    a_r8_last_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_words[(NWORDS-1)*WORD_W]);

    a_r10_ignore_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && cmd_wr) |=> $stable(cmd_reg));

    a_r11_single_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status & ~$past(status)) <= 1);
endmodule

bind card_cmd_engine ccmd_checker #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .card_ack   (card_ack),
    .card_req   (card_req),
    .card_index (card_index),
    .card_arg   (card_arg),
    .cmd_reg    (cmd_reg),
    .rsp_words  (rsp_words),
    .status     (status),
    .busy       (busy),
    .data_start (data_start)
);

// File: tb/card_cmd_engine_tb.sv
module card_cmd_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [31:0]  cmd_wdata = '0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic [7:0]   status_clr = '0;
    logic         card_ack = 1'b0;
    logic         card_err = 1'b0;
    logic [4:0]   card_len = '0;
    logic [127:0] card_resp = '0;
    logic         card_req;
    logic [5:0]   card_index;
    logic [31:0]  card_arg;
    logic [10:0]  cmd_reg;
    logic [127:0] rsp_words;
    logic [7:0]   status;
    logic         busy;
    logic         data_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    card_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata), .status_clr(status_clr),
        .card_ack(card_ack), .card_err(card_err), .card_len(card_len),
        .card_resp(card_resp), .card_req(card_req), .card_index(card_index),
        .card_arg(card_arg), .cmd_reg(cmd_reg), .rsp_words(rsp_words),
        .status(status), .busy(busy), .data_start(data_start)
    );

    // vector: [10] expect resp, [9] long, [8] card err, [7:3] len, [2:0] {tmo, ok, sent}
    localparam int NVEC = 10;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 5'd4,  3'b010},
        {1'b1, 1'b1, 1'b0, 5'd16, 3'b010},
        {1'b1, 1'b1, 1'b0, 5'd4,  3'b100},
        {1'b1, 1'b0, 1'b0, 5'd0,  3'b100},
        {1'b1, 1'b0, 1'b0, 5'd8,  3'b100},
        {1'b0, 1'b0, 1'b0, 5'd0,  3'b001},
        {1'b0, 1'b0, 1'b0, 5'd9,  3'b001},
        {1'b1, 1'b0, 1'b1, 5'd4,  3'b100},
        {1'b1, 1'b0, 1'b0, 5'd16, 3'b010},
        {1'b0, 1'b0, 1'b1, 5'd0,  3'b100}
    };

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] make_bytes(input int seed);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[8*k +: 8] = {seed[3:0], k[3:0]} ^ 8'h5A;
        return r;
    endfunction

    function automatic logic [127:0] pack_ref(input logic [127:0] by, input logic [4:0] len);
        logic [127:0] r;
        for (int w = 0; w < 4; w++)
            r[32*w +: 32] = {by[8*(4*w) +: 8], by[8*(4*w+1) +: 8], by[8*(4*w+2) +: 8], by[8*(4*w+3) +: 8]};
        if (len == 5'd4) r[127:32] = '0;
        else             r[96] = 1'b0;
        return r;
    endfunction

    task automatic clear_all();
        @(negedge clk) status_clr = 8'hFF;
        @(negedge clk) status_clr = 8'h00;
    endtask

    // Issues a command and serves the card; returns at the negedge after completion.
    task automatic run_cmd(input logic [10:0] word, input logic [31:0] arg, input logic err,
                           input logic [4:0] len, input logic [127:0] by, input bit clr_same);
        @(negedge clk) begin arg_wr = 1'b1; arg_wdata = arg; end
        @(negedge clk) begin arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = {21'b0, word}; end
        @(negedge clk) cmd_wr = 1'b0;
        chk(card_req === 1'b1, "R1 request raised", 128'(card_req), 128'd1);
        chk(card_index === word[5:0], "R1 index", 128'(card_index), 128'(word[5:0]));
        chk(card_arg === arg, "R2 argument", 128'(card_arg), 128'(arg));
        card_ack = 1'b1; card_err = err; card_len = len; card_resp = by;
        @(negedge clk) card_ack = 1'b0;
        chk(data_start === 1'b1, "R9 start pulse", 128'(data_start), 128'd1);
        if (clr_same) status_clr = 8'hFF;
        @(negedge clk) status_clr = 8'h00;
        chk(data_start === 1'b0 && busy === 1'b0, "R9 single pulse", 128'({data_start, busy}), 128'd0);
        chk(cmd_reg[10] === 1'b0, "R4 enable self-clear", 128'(cmd_reg), 128'(word & 11'h3FF));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] exp_words;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status === 8'h00 && rsp_words === '0 && cmd_reg === '0, "R12 reset regs",
            {status, cmd_reg}, 128'd0);
        chk(busy === 1'b0 && card_req === 1'b0 && data_start === 1'b0, "R12 reset outputs",
            128'({busy, card_req, data_start}), 128'd0);
        exp_words = '0;

        // Table-driven outcome and packing checks (R5, R6, R7, R8)
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            logic [10:0] word;
            logic [127:0] by;
            logic [7:0] exp_st;
            v    = VEC[i];
            by   = make_bytes(i);
            word = {1'b1, 1'b0, 1'b0, v[9], v[10], 6'(i + 3)};
            clear_all();
            run_cmd(word, 32'hA500_0000 + i * 32'h0101_0101, v[8], v[7:3], by, 1'b0);
            exp_st = {v[0], v[1], 3'b000, v[2], 2'b00};
            if (v[1]) exp_words = pack_ref(by, v[7:3]);
            chk(status === exp_st, $sformatf("R5 R6 status vector %0d", i), 128'(status), 128'(exp_st));
            chk(rsp_words === exp_words, $sformatf("R7 R8 words vector %0d", i), rsp_words, exp_words);
        end

        // R4: enable clear only stores
        clear_all();
        @(negedge clk) begin cmd_wr = 1'b1; cmd_wdata = 32'h0000_0045; end
        @(negedge clk) cmd_wr = 1'b0;
        chk(cmd_reg === 11'h045, "R4 stored word", 128'(cmd_reg), 128'h045);
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && card_req === 1'b0, "R4 no issue", 128'({busy, card_req}), 128'd0);

        // R3: pending command is dropped
        @(negedge clk) begin cmd_wr = 1'b1; cmd_wdata = 32'h0000_0607; end
        @(negedge clk) cmd_wr = 1'b0;
        chk(card_req === 1'b0 && data_start === 1'b0, "R3 no request", 128'({card_req, data_start}), 128'd0);
        @(negedge clk);
        chk(cmd_reg === 11'h207 && busy === 1'b0, "R3 enable cleared", 128'(cmd_reg), 128'h207);
        chk(status === 8'h00, "R3 status untouched", 128'(status), 128'd0);

        // R10: writes while busy are ignored
        @(negedge clk) begin arg_wr = 1'b1; arg_wdata = 32'h1234_5678; end
        @(negedge clk) begin arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = 32'h0000_0411; end
        @(negedge clk) begin cmd_wdata = 32'h0000_042A; arg_wr = 1'b1; arg_wdata = 32'hDEAD_BEEF; end
        @(negedge clk) begin cmd_wr = 1'b0; arg_wr = 1'b0; end
        chk(cmd_reg === 11'h411, "R10 command kept", 128'(cmd_reg), 128'h411);
        chk(card_arg === 32'h1234_5678, "R10 argument kept", 128'(card_arg), 128'h12345678);
        card_ack = 1'b1; card_err = 1'b0; card_len = 5'd0;
        @(negedge clk) card_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && card_req === 1'b0 && status === 8'h80, "R10 single command ran",
            128'({busy, card_req, status}), 128'h80);

        // R11: timeout standing, then clear-all in completion cycle while new flag sets
        clear_all();
        run_cmd(11'h444, 32'h0, 1'b1, 5'd4, make_bytes(3), 1'b0);
        chk(status === 8'h04, "R11 timeout sticky", 128'(status), 128'h04);
        run_cmd(11'h545, 32'hFFFF_FFFF, 1'b0, 5'd4, make_bytes(12), 1'b1);
        chk(status === 8'h40, "R11 set wins over clear", 128'(status), 128'h40);
        exp_words = pack_ref(make_bytes(12), 5'd4);
        chk(rsp_words === exp_words, "R1 R7 interrupt bit has no effect", rsp_words, exp_words);
        @(negedge clk) status_clr = 8'h04;
        @(negedge clk) status_clr = 8'h00;
        chk(status === 8'h40, "R11 unrelated clear", 128'(status), 128'h40);
        @(negedge clk) status_clr = 8'h40;
        @(negedge clk) status_clr = 8'h00;
        chk(status === 8'h00, "R11 targeted clear", 128'(status), 128'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule